// File: doc/BRIEF.md
# Calibration Cycle Sequencer

This block paces the linearity self-calibration of a pipelined converter. Each falling edge on the active-low trigger input `cal_n` starts one unit calibration cycle of seven clocks. A step index walks through the cycle, and one strobe per correction target fires on a fixed step: amplifier offset, upper reference bias and lower reference bias. The arithmetic that adjusts those targets sits elsewhere and listens to the strobes.

During each cycle the fine comparator is lent to the calibration logic. For four clocks after the cycle ends, the block raises `lsb_hold` so that the output stage keeps the five least significant result bits frozen. Trigger edges that arrive while a cycle or its hold window is in progress are dropped and counted. Completed cycles are grouped in sevens into calibration processes. The process count saturates, because a few hundred triggers are enough for full convergence.

The controller has three states. IDLE waits for a trigger edge and moves to RUN when one arrives (transition *start*). RUN counts steps 0 to 6 and then moves to HOLD (transition *finish*). HOLD counts four clocks and returns to IDLE (transition *release*). A synchronous reset forces IDLE from any state (transition *abort*).

Top module: `cal_cycle_sequencer`

## Requirements
- R1: A trigger edge is `cal_n` sampled 1 at one rising clock edge and 0 at the next, or `cal_n` sampled 0 at the first rising edge after reset. An edge seen in IDLE makes `busy`=1 and `step`=0 from that clock edge on. Holding `cal_n` low does not start another cycle.
- R2: `busy` stays 1 for exactly 7 clocks while `step` counts 0,1,...,6, one per clock. Outside a cycle, `step` reads 0.
- R3: `tgt_strobe[0]` (offset) is 1 exactly while busy at step 1. `tgt_strobe[1]` (upper bias) is 1 exactly at step 2. `tgt_strobe[2]` (lower bias) is 1 exactly at step 3. At all other times every strobe is 0.
- R4: `lsb_hold` is 1 for exactly the 4 clocks that follow the last busy clock, and never together with `busy`.
- R5: A trigger edge seen while `busy` or `lsb_hold` is 1 does not change the cycle timing. It increments `drop_count`, which saturates at 255.
- R6: `cyc_in_proc` increments as each cycle's step-6 clock ends. After the seventh cycle it wraps from 6 to 0, and `proc_count` increments in the same clock.
- R7: `proc_count` saturates at 127 and holds there.
- R8: A synchronous reset (`rst`=1 at a rising edge) clears `busy`, `step`, `lsb_hold`, all strobes, `cyc_in_proc`, `proc_count` and `drop_count`, and treats `cal_n` as previously high.
- R9: An edge seen on the first clock after the hold window ends is accepted and starts a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_n | input | 1 | Calibration trigger, active low, acts on its falling edge |
| busy | output | 1 | A unit cycle is running |
| step | output | 3 | Step index 0..6 within the running cycle |
| tgt_strobe | output | 3 | Per-target adjust strobes: bit0 offset, bit1 upper bias, bit2 lower bias |
| lsb_hold | output | 1 | Freeze request for the five low result bits |
| cyc_in_proc | output | 3 | Completed cycles within the current process, 0..6 |
| proc_count | output | 7 | Completed processes, saturating |
| drop_count | output | 8 | Trigger edges ignored while occupied, saturating |

## Verification
The bench places trigger edges on the last hold clock and on the first idle clock after it. A design that ends the hold window one clock early or late either accepts the first of these edges or drops the second. Level-low triggers that last many clocks are applied, and a design that reacts to level instead of edge would restart cycles. Runs of 900 cycles drive the process count into saturation, and toggling triggers push the drop count past 255, where a wrapping counter would read a small number. Resets land in the middle of cycles and while `cal_n` is low, and a design that keeps the old sampled trigger level would miss or invent the first edge.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } cal_state_e;

endpackage

// File: rtl/cal_fall_detect.sv
module cal_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic trig_n_i,
    output logic fall_o
);

    logic trig_q;

    // Reset value high: a low level right after reset counts as an edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b1;
        end else begin
            trig_q <= trig_n_i;
        end
    end

    assign fall_o = trig_q & ~trig_n_i;

endmodule

// File: rtl/cal_sat_counter.sv
module cal_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/cal_cycle_fsm.sv
module cal_cycle_fsm
    import cal_seq_pkg::*;
#(
    parameter int CYCLE_LEN = 7,
    parameter int HOLD_LEN  = 4,
    parameter int STEP_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_i,
    output logic              busy_o,
    output logic              hold_o,
    output logic [STEP_W-1:0] step_o,
    output logic              cycle_done_o,
    output logic              drop_o
);

    localparam int MAX_LEN = (CYCLE_LEN > HOLD_LEN) ? CYCLE_LEN : HOLD_LEN;
    localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam logic [CNT_W-1:0] RUN_LAST  = CNT_W'(CYCLE_LEN - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_LEN - 1);

    cal_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions: start, finish, release
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (fall_i) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (cnt_q == RUN_LAST) begin
                    state_d = ST_HOLD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_q == HOLD_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy_o       = (state_q == ST_RUN);
        hold_o       = (state_q == ST_HOLD);
        step_o       = busy_o ? cnt_q[STEP_W-1:0] : '0;
        cycle_done_o = busy_o && (cnt_q == RUN_LAST);
        drop_o       = fall_i && (state_q != ST_IDLE);
    end

endmodule

// File: rtl/cal_target_strobes.sv
module cal_target_strobes #(
    parameter int NUM_TGT   = 3,
    parameter int BASE_STEP = 1,
    parameter int STEP_W    = 3
) (
    input  logic               busy_i,
    input  logic [STEP_W-1:0]  step_i,
    output logic [NUM_TGT-1:0] strobe_o
);

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        assign strobe_o[t] = busy_i && (step_i == STEP_W'(BASE_STEP + t));
    end

endmodule

// File: rtl/cal_progress.sv
module cal_progress #(
    parameter int CYCLES_PER_PROC = 7,
    parameter int CYC_W           = 3,
    parameter int PROC_W          = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cycle_done_i,
    output logic [CYC_W-1:0]  cyc_idx_o,
    output logic [PROC_W-1:0] proc_cnt_o
);

    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYCLES_PER_PROC - 1);

    logic [CYC_W-1:0] cyc_q;
    logic             proc_wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
        end else if (cycle_done_i) begin
            cyc_q <= (cyc_q == CYC_LAST) ? '0 : cyc_q + 1'b1;
        end
    end

    assign proc_wrap = cycle_done_i && (cyc_q == CYC_LAST);
    assign cyc_idx_o = cyc_q;

    cal_sat_counter #(.W(PROC_W)) u_proc_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (proc_wrap),
        .count_o (proc_cnt_o)
    );

endmodule

// File: rtl/cal_cycle_sequencer.sv
module cal_cycle_sequencer #(
    parameter int CYCLE_LEN       = 7,
    parameter int HOLD_LEN        = 4,
    parameter int CYCLES_PER_PROC = 7,
    parameter int PROC_W          = 7,
    parameter int DROP_W          = 8,
    parameter int NUM_TGT         = 3,
    parameter int TGT_BASE_STEP   = 1,
    localparam int STEP_W = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1,
    localparam int CYC_W  = (CYCLES_PER_PROC > 1) ? $clog2(CYCLES_PER_PROC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cal_n,
    output logic               busy,
    output logic [STEP_W-1:0]  step,
    output logic [NUM_TGT-1:0] tgt_strobe,
    output logic               lsb_hold,
    output logic [CYC_W-1:0]   cyc_in_proc,
    output logic [PROC_W-1:0]  proc_count,
    output logic [DROP_W-1:0]  drop_count
);

    logic fall;
    logic cycle_done;
    logic drop;

    cal_fall_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .trig_n_i (cal_n),
        .fall_o   (fall)
    );

    cal_cycle_fsm #(
        .CYCLE_LEN (CYCLE_LEN),
        .HOLD_LEN  (HOLD_LEN),
        .STEP_W    (STEP_W)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .fall_i       (fall),
        .busy_o       (busy),
        .hold_o       (lsb_hold),
        .step_o       (step),
        .cycle_done_o (cycle_done),
        .drop_o       (drop)
    );

    cal_target_strobes #(
        .NUM_TGT   (NUM_TGT),
        .BASE_STEP (TGT_BASE_STEP),
        .STEP_W    (STEP_W)
    ) u_strobes (
        .busy_i   (busy),
        .step_i   (step),
        .strobe_o (tgt_strobe)
    );

    cal_progress #(
        .CYCLES_PER_PROC (CYCLES_PER_PROC),
        .CYC_W           (CYC_W),
        .PROC_W          (PROC_W)
    ) u_progress (
        .clk          (clk),
        .rst          (rst),
        .cycle_done_i (cycle_done),
        .cyc_idx_o    (cyc_in_proc),
        .proc_cnt_o   (proc_count)
    );

    cal_sat_counter #(.W(DROP_W)) u_drop_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (drop),
        .count_o (drop_count)
    );

endmodule

// File: rtl/cal_cycle_sequencer_chk.sv
module cal_cycle_sequencer_chk #(
    parameter int CYCLE_LEN       = 7,
    parameter int HOLD_LEN        = 4,
    parameter int CYCLES_PER_PROC = 7,
    parameter int STEP_W          = 3,
    parameter int CYC_W           = 3,
    parameter int PROC_W          = 7,
    parameter int DROP_W          = 8,
    parameter int NUM_TGT         = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               cal_n,
    input logic               busy,
    input logic [STEP_W-1:0]  step,
    input logic [NUM_TGT-1:0] tgt_strobe,
    input logic               lsb_hold,
    input logic [CYC_W-1:0]   cyc_in_proc,
    input logic [PROC_W-1:0]  proc_count,
    input logic [DROP_W-1:0]  drop_count
);

    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(CYCLE_LEN - 1);
    localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(CYCLES_PER_PROC - 1);
    localparam int HR_W = $clog2(HOLD_LEN + 1);
    localparam logic [HR_W-1:0] HR_LAST = HR_W'(HOLD_LEN - 1);
    localparam logic [HR_W-1:0] HR_LEN  = HR_W'(HOLD_LEN);

    logic            rst_d;
    logic            prev_n;
    logic            trig;
    logic [HR_W-1:0] hold_run;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            prev_n   <= 1'b1;
            hold_run <= '0;
        end else begin
            prev_n   <= cal_n;
            hold_run <= (lsb_hold && (hold_run != '1)) ? hold_run + 1'b1 : '0;
        end
    end

    assign trig = prev_n & ~cal_n;

    // R1: an edge while fully idle starts a cycle at step 0
    a_r1_start: assert property (@(posedge clk) disable iff (rst || rst_d)
        (!busy && !lsb_hold && trig) |=> (busy && step == '0));

    // R2: step advances by one while busy
    a_r2_step_advance: assert property (@(posedge clk) disable iff (rst || rst_d)
        (busy && step != STEP_LAST) |=> (busy && step == $past(step) + 1'b1));

    // R2: cycle ends after the last step
    a_r2_cycle_end: assert property (@(posedge clk) disable iff (rst || rst_d)
        (busy && step == STEP_LAST) |=> !busy);

    // R3: at most one target strobe, only while busy
    a_r3_strobe_onehot: assert property (@(posedge clk) disable iff (rst || rst_d)
        $onehot0(tgt_strobe));
    a_r3_strobe_busy: assert property (@(posedge clk) disable iff (rst || rst_d)
        (|tgt_strobe) |-> busy);

    // R4: hold follows the cycle, never overlaps, lasts HOLD_LEN clocks
    a_r4_hold_follows: assert property (@(posedge clk) disable iff (rst || rst_d)
        $fell(busy) |-> lsb_hold);
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst || rst_d)
        busy |-> !lsb_hold);
    a_r4_hold_bound: assert property (@(posedge clk) disable iff (rst || rst_d)
        lsb_hold |-> (hold_run < HR_LEN));
    a_r4_hold_full: assert property (@(posedge clk) disable iff (rst || rst_d)
        $fell(lsb_hold) |-> ($past(hold_run) == HR_LAST));

    // R5: an edge while occupied is counted
    a_r5_drop_count: assert property (@(posedge clk) disable iff (rst || rst_d)
        ((busy || lsb_hold) && trig && drop_count != '1)
            |=> (drop_count == $past(drop_count) + 1'b1));

    // R6: processes advance only when the cycle index wraps
    a_r6_proc_on_wrap: assert property (@(posedge clk) disable iff (rst || rst_d)
        (proc_count != $past(proc_count))
            |-> (cyc_in_proc == '0 && $past(cyc_in_proc) == CYC_LAST));

    // R7: a saturated process count stays saturated
    a_r7_proc_saturate: assert property (@(posedge clk) disable iff (rst || rst_d)
        (proc_count == '1) |=> (proc_count == '1));

    // R6: cycle index stays in range
    always @(posedge clk) begin
        if (!rst) begin
            a_r6_cyc_range: assert (int'(cyc_in_proc) < CYCLES_PER_PROC);
        end
    end

endmodule

bind cal_cycle_sequencer cal_cycle_sequencer_chk #(
    .CYCLE_LEN       (CYCLE_LEN),
    .HOLD_LEN        (HOLD_LEN),
    .CYCLES_PER_PROC (CYCLES_PER_PROC),
    .STEP_W          (STEP_W),
    .CYC_W           (CYC_W),
    .PROC_W          (PROC_W),
    .DROP_W          (DROP_W),
    .NUM_TGT         (NUM_TGT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cal_n       (cal_n),
    .busy        (busy),
    .step        (step),
    .tgt_strobe  (tgt_strobe),
    .lsb_hold    (lsb_hold),
    .cyc_in_proc (cyc_in_proc),
    .proc_count  (proc_count),
    .drop_count  (drop_count)
);

// File: tb/cal_cycle_sequencer_bench.sv
`timescale 1ns/1ps
module cal_cycle_sequencer_bench;

    localparam int RUN_CLK  = 7;
    localparam int HOLD_CLK = 4;
    localparam int PER_PROC = 7;
    localparam int PROC_MAX = 127;
    localparam int DROP_MAX = 255;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cal_n = 1'b1;
    logic       busy;
    logic [2:0] step;
    logic [2:0] tgt_strobe;
    logic       lsb_hold;
    logic [2:0] cyc_in_proc;
    logic [6:0] proc_count;
    logic [7:0] drop_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference state, advanced on each rising edge from the requirements
    int m_age  = 0;   // 0 idle, 1..7 busy, 8..11 hold
    int m_cyc  = 0;
    int m_proc = 0;
    int m_drop = 0;
    int m_idle = 100;
    bit m_prev = 1'b1;
    bit m_quick = 1'b0;
    bit m_rst_seen = 1'b1;

    always #10 clk = ~clk;

    cal_cycle_sequencer u_cal_cycle_sequencer (
        .clk         (clk),
        .rst         (rst),
        .cal_n       (cal_n),
        .busy        (busy),
        .step        (step),
        .tgt_strobe  (tgt_strobe),
        .lsb_hold    (lsb_hold),
        .cyc_in_proc (cyc_in_proc),
        .proc_count  (proc_count),
        .drop_count  (drop_count)
    );

    always @(posedge clk) begin
        bit fall;
        if (rst) begin
            m_age = 0; m_cyc = 0; m_proc = 0; m_drop = 0;
            m_idle = 100; m_prev = 1'b1; m_quick = 1'b0; m_rst_seen = 1'b1;
        end else begin
            m_rst_seen = 1'b0;
            fall = m_prev && !cal_n;
            if (m_age == 0) begin
                if (fall) begin
                    m_quick = (m_idle == 0);
                    m_age = 1;
                end else begin
                    m_idle++;
                end
            end else begin
                if (fall && m_drop < DROP_MAX) m_drop++;
                if (m_age == RUN_CLK) begin
                    if (m_cyc == PER_PROC - 1) begin
                        m_cyc = 0;
                        if (m_proc < PROC_MAX) m_proc++;
                    end else begin
                        m_cyc++;
                    end
                end
                if (m_age == RUN_CLK + HOLD_CLK) begin
                    m_age = 0;
                    m_idle = 0;
                end else begin
                    m_age++;
                end
            end
            m_prev = cal_n;
        end
    end

    function automatic int exp_busy(int age);
        return (age >= 1 && age <= RUN_CLK) ? 1 : 0;
    endfunction

    function automatic int exp_step(int age);
        return exp_busy(age) ? age - 1 : 0;
    endfunction

    function automatic int exp_hold(int age);
        return (age > RUN_CLK && age <= RUN_CLK + HOLD_CLK) ? 1 : 0;
    endfunction

    function automatic int exp_strobe(int age);
        int s;
        s = 0;
        if (exp_busy(age) != 0) begin
            if (exp_step(age) == 1) s = 1;
            if (exp_step(age) == 2) s = 2;
            if (exp_step(age) == 3) s = 4;
        end
        return s;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string rq;
        if (m_rst_seen) begin
            rq = "R8";
        end else if (m_age == 1) begin
            rq = m_quick ? "R9" : "R1";
        end else begin
            rq = "R2";
        end
        chk(rq, "busy", int'(busy), exp_busy(m_age));
        chk(m_rst_seen ? "R8" : "R2", "step", int'(step), exp_step(m_age));
        chk(m_rst_seen ? "R8" : "R3", "tgt_strobe", int'(tgt_strobe), exp_strobe(m_age));
        chk(m_rst_seen ? "R8" : "R4", "lsb_hold", int'(lsb_hold), exp_hold(m_age));
        chk(m_rst_seen ? "R8" : "R6", "cyc_in_proc", int'(cyc_in_proc), m_cyc);
        chk(m_rst_seen ? "R8" : ((m_proc == PROC_MAX) ? "R7" : "R6"), "proc_count",
            int'(proc_count), m_proc);
        chk(m_rst_seen ? "R8" : "R5", "drop_count", int'(drop_count), m_drop);
    endtask

    // Compare outputs of the previous edge, then drive the next inputs
    task automatic tick(bit c, bit r = 1'b0);
        @(negedge clk);
        compare_all();
        cal_n = c;
        rst   = r;
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) tick(1'b1, 1'b1);
        tick(1'b1);
        tick(1'b1);

        // R1: long low level starts only one cycle
        tick(1'b0);
        repeat (30) tick(1'b0);
        repeat (3) tick(1'b1);

        // R5: edges during busy and during hold are dropped
        tick(1'b0);
        repeat (2) tick(1'b1);
        tick(1'b0);
        repeat (5) tick(1'b1);
        tick(1'b0);
        repeat (10) tick(1'b1);

        // R5: edge on the last hold clock is dropped
        tick(1'b0);
        repeat (10) tick(1'b1);
        tick(1'b0);
        repeat (20) tick(1'b1);

        // R9: edge on the first idle clock after hold is accepted
        for (int k = 0; k < 9; k++) begin
            tick(1'b0);
            repeat (11) tick(1'b1);
        end
        repeat (15) tick(1'b1);

        // R8: reset while busy and while cal_n is low
        tick(1'b0);
        repeat (3) tick(1'b1);
        tick(1'b0, 1'b1);
        tick(1'b0);
        repeat (12) tick(1'b1);

        // Random mix with occasional resets
        for (int k = 0; k < 4000; k++) begin
            bit c;
            bit r;
            c = ($urandom_range(0, 3) != 0);
            r = ($urandom_range(0, 599) == 0);
            tick(c, r);
            if (r) tick(c, 1'b1);
        end

        // R7: drive the process count into saturation
        tick(1'b1, 1'b1);
        tick(1'b1);
        for (int k = 0; k < 900; k++) begin
            tick(1'b0);
            repeat (13) tick(1'b1);
        end

        // R5: drop counter saturation with a toggling trigger
        for (int k = 0; k < 3000; k++) begin
            tick(k[0]);
        end
        repeat (14) tick(1'b1);

        // R8: final reset clears saturated counters
        tick(1'b1, 1'b1);
        tick(1'b1);
        tick(1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule